// File: doc/BRIEF.md
# System MMU Control and Fault Register Block

This block is the register front end of a system memory-management unit. Software reaches it through a plain single-cycle register port. It uses that port to turn address translation on and off, to hold the page table base, and to issue whole-TLB or single-page invalidations. The block turns these register writes into level signals and one-cycle strobes for the translation datapath. The datapath and the TLB sit outside the block.

The datapath reports each translation fault with a type code and the faulting address. The block records the fault in a sticky status vector that software clears by writing ones, and it latches the address into the capture register for that class of fault. It raises an interrupt while any status bit is pending. A fault also stalls the datapath until software writes the enable code again. Software can request the same stall on purpose and poll an acknowledge bit, which tells it that traffic has drained. The block also stores two prefetch address windows and returns a fixed version word.

Top module: `smmu_ctrl_regs`

## Requirements
- R1: After reset, translation, stall, interrupt and all strobes are low, and the control, status, interrupt-status and page-table-base registers read 0.
- R2: Writing 0x5 to the control register (offset 0x000) sets `xlate_en` and clears `stall` in the next cycle, and the register then reads 0x5. Writing 0x0 clears both. Any other value written there is ignored.
- R3: Writing 0x7 to the control register sets `xlate_en` and `stall`, and it then reads 0x7. Bit 0 of the status register (offset 0x008) becomes 1 one cycle after `dp_idle` is sampled high while stalled. It returns to 0 after a write of 0x5 or 0x0.
- R4: A write to offset 0x00C with bit 0 set gives a `inv_all` pulse in the cycle after the write, one cycle wide. The same write with bit 0 clear gives no pulse.
- R5: A write to offset 0x010 with bit 0 set gives a one-cycle `inv_entry` pulse in the cycle after the write. During that pulse, `inv_addr` equals the written value with bits [11:0] cleared. With bit 0 clear there is no pulse.
- R6: While translation is enabled, a fault of type T (0 to 7) sets bit T of the interrupt status register (offset 0x018), raises `irq` and raises `stall` in the next cycle. The type bits are: 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write protection.
- R7: The fault address is captured by type. Type 0 goes to 0x024, types 2, 6 and 7 go to 0x028, types 1, 4 and 5 go to 0x02C, and type 3 goes to 0x030.
- R8: A fault whose status bit is already set does not change the captured address.
- R9: Writing ones to offset 0x01C clears those status bits, and `irq` falls once none remain. A new fault wins over a clear of the same bit in the same cycle.
- R10: Faults reported while translation is disabled change no status, no address and no output.
- R11: The page table base (0x014) and the window registers read back what was written. Window 0 starts at 0x04C and ends at 0x050. Window 1 starts at 0x054 and ends at 0x058.
- R12: Offset 0x034 reads the major version in bits [31:28] and the minor version in bits [27:24]; the defaults are 3 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, same cycle |
| dp_idle | input | 1 | Datapath has no outstanding traffic |
| fault_valid | input | 1 | Datapath reports a fault this cycle |
| fault_type | input | 3 | Fault class code |
| fault_addr | input | DATA_W | Faulting device address |
| xlate_en | output | 1 | Translation enabled |
| stall | output | 1 | Hold datapath traffic |
| inv_all | output | 1 | Invalidate whole TLB strobe |
| inv_entry | output | 1 | Invalidate single page strobe |
| inv_addr | output | DATA_W | Page address for `inv_entry` |
| irq | output | 1 | Any fault pending |

## Verification
The hardest state to reach is the block acknowledge. It only rises on the edge after `dp_idle` is seen during a stall, so the stimulus holds `dp_idle` low through the block request. It then shows the acknowledge still at 0 in the cycle where `dp_idle` first goes high, and at 1 one cycle later. The second hard case is a fault and a clear of the same status bit landing in the same cycle. The bench drives the fault inputs and the clear write on the same falling edge, so both reach the design at the same rising edge.

// File: rtl/smmu_ctrl_regs.sv
module smmu_ctrl_regs #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int VER_MAJOR  = 3,
  parameter int VER_MINOR  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dp_idle,
  input  logic              fault_valid,
  input  logic [2:0]        fault_type,
  input  logic [DATA_W-1:0] fault_addr,
  output logic              xlate_en,
  output logic              stall,
  output logic              inv_all,
  output logic              inv_entry,
  output logic [DATA_W-1:0] inv_addr,
  output logic              irq
);
  localparam int NFAULT = 8;
  localparam int NWIN   = 2;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] A_INVA  = ADDR_W'('h00C);
  localparam logic [ADDR_W-1:0] A_INVE  = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] A_PTB   = ADDR_W'('h014);
  localparam logic [ADDR_W-1:0] A_IST   = ADDR_W'('h018);
  localparam logic [ADDR_W-1:0] A_ICLR  = ADDR_W'('h01C);
  localparam logic [ADDR_W-1:0] A_FPAGE = ADDR_W'('h024);
  localparam logic [ADDR_W-1:0] A_FWR   = ADDR_W'('h028);
  localparam logic [ADDR_W-1:0] A_FRD   = ADDR_W'('h02C);
  localparam logic [ADDR_W-1:0] A_FBUS  = ADDR_W'('h030);
  localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'('h034);
  localparam logic [ADDR_W-1:0] A_WIN   = ADDR_W'('h04C);
  localparam logic [DATA_W-1:0] C_ON    = DATA_W'(5);
  localparam logic [DATA_W-1:0] C_BLK   = DATA_W'(7);
  localparam logic [DATA_W-1:0] VER_WORD =
    DATA_W'({4'(VER_MAJOR), 4'(VER_MINOR)}) << (DATA_W - 8);

  logic              en_q, stall_q, blk_ack, inv_all_q, inv_entry_q;
  logic [DATA_W-1:0] inv_addr_q, ptb_q, fa_page, fa_wr, fa_rd, fa_bus;
  logic [NFAULT-1:0] int_q;
  logic [DATA_W-1:0] win_s [NWIN];
  logic [DATA_W-1:0] win_e [NWIN];

  wire wr_ctrl    = reg_we && reg_addr == A_CTRL;
  wire cmd_off    = wr_ctrl && reg_wdata == '0;
  wire cmd_on     = wr_ctrl && reg_wdata == C_ON;
  wire cmd_blk    = wr_ctrl && reg_wdata == C_BLK;
  wire fault_take = fault_valid && en_q;
  wire [NFAULT-1:0] set_v = fault_take ? NFAULT'(1) << fault_type : '0;
  wire [NFAULT-1:0] clr_v = (reg_we && reg_addr == A_ICLR) ? reg_wdata[NFAULT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      stall_q <= 1'b0;
      blk_ack <= 1'b0;
    end else begin
      if (cmd_off) begin
        en_q <= 1'b0;
        stall_q <= 1'b0;
      end else if (cmd_blk) begin
        en_q <= 1'b1;
        stall_q <= 1'b1;
      end else if (cmd_on) begin
        en_q <= 1'b1;
        stall_q <= fault_take;
      end else if (fault_take) begin
        stall_q <= 1'b1;
      end
      if (cmd_off || cmd_on) blk_ack <= 1'b0;
      else if (stall_q && dp_idle) blk_ack <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_all_q <= 1'b0;
      inv_entry_q <= 1'b0;
      inv_addr_q <= '0;
      ptb_q <= '0;
    end else begin
      inv_all_q <= reg_we && reg_addr == A_INVA && reg_wdata[0];
      inv_entry_q <= reg_we && reg_addr == A_INVE && reg_wdata[0];
      if (reg_we && reg_addr == A_INVE && reg_wdata[0])
        inv_addr_q <= {reg_wdata[DATA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      if (reg_we && reg_addr == A_PTB) ptb_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q <= '0;
      fa_page <= '0;
      fa_wr <= '0;
      fa_rd <= '0;
      fa_bus <= '0;
    end else begin
      int_q <= (int_q & ~clr_v) | set_v;
      if (fault_take && !int_q[fault_type]) begin
        case (fault_type)
          3'd0:                fa_page <= fault_addr;
          3'd3:                fa_bus  <= fault_addr;
          3'd1, 3'd4, 3'd5:    fa_rd   <= fault_addr;
          default:             fa_wr   <= fault_addr;
        endcase
      end
    end
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] A_S = A_WIN + ADDR_W'(8 * w);
    localparam logic [ADDR_W-1:0] A_E = A_S + ADDR_W'(4);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_s[w] <= '0;
        win_e[w] <= '0;
      end else begin
        if (reg_we && reg_addr == A_S) win_s[w] <= reg_wdata;
        if (reg_we && reg_addr == A_E) win_e[w] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = !en_q ? '0 : (stall_q ? C_BLK : C_ON);
      A_STAT:  reg_rdata = DATA_W'(blk_ack);
      A_PTB:   reg_rdata = ptb_q;
      A_IST:   reg_rdata = DATA_W'(int_q);
      A_FPAGE: reg_rdata = fa_page;
      A_FWR:   reg_rdata = fa_wr;
      A_FRD:   reg_rdata = fa_rd;
      A_FBUS:  reg_rdata = fa_bus;
      A_VER:   reg_rdata = VER_WORD;
      default: begin
        for (int w = 0; w < NWIN; w++) begin
          if (reg_addr == A_WIN + ADDR_W'(8 * w))     reg_rdata = win_s[w];
          if (reg_addr == A_WIN + ADDR_W'(8 * w + 4)) reg_rdata = win_e[w];
        end
      end
    endcase
  end

  assign xlate_en  = en_q;
  assign stall     = stall_q;
  assign inv_all   = inv_all_q;
  assign inv_entry = inv_entry_q;
  assign inv_addr  = inv_addr_q;
  assign irq       = |int_q;
endmodule

// File: rtl/smmu_ctrl_regs_chk.sv
module smmu_ctrl_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              dp_idle,
  input logic              fault_valid,
  input logic              xlate_en,
  input logic              stall,
  input logic              inv_all,
  input logic              inv_entry,
  input logic [DATA_W-1:0] inv_addr,
  input logic              irq,
  input logic              blk_ack
);
  wire wr_ctrl = reg_we && reg_addr == ADDR_W'('h000);

  p_enable_unstalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && reg_wdata == DATA_W'(5) && !fault_valid |=> xlate_en && !stall);

  p_disable_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && reg_wdata == '0 |=> !xlate_en && !stall && !blk_ack);

  p_ack_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_ack) |-> $past(dp_idle) && $past(stall));

  p_ack_only_stalled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ack |-> stall);

  p_flush_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == ADDR_W'('h00C) && reg_wdata[0] |=> inv_all);

  p_entry_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_entry |-> inv_addr[11:0] == '0);

  p_fault_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && xlate_en && !wr_ctrl |=> irq && stall);

  p_off_fault_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !xlate_en && !irq |=> !irq);
endmodule

bind smmu_ctrl_regs smmu_ctrl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .dp_idle(dp_idle), .fault_valid(fault_valid),
  .xlate_en(xlate_en), .stall(stall), .inv_all(inv_all),
  .inv_entry(inv_entry), .inv_addr(inv_addr), .irq(irq), .blk_ack(blk_ack)
);

// File: tb/test_smmu_ctrl_regs.sv
module test_smmu_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int W_RD = 0, W_EN = 1, W_STALL = 2, W_IRQ = 3, W_INVA = 4,
                 W_INVE = 5, W_INVADDR = 6;

  typedef struct {
    int          what;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic clk = 0, rst_n = 0, reg_we = 0, dp_idle = 0, fault_valid = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0, fault_addr = '0, reg_rdata, inv_addr;
  logic [2:0] fault_type = '0;
  logic xlate_en, stall, inv_all, inv_entry, irq;
  int checks = 0, errors = 0;
  bit done = 0;
  item_t q[$];
  event ev_push;

  always #(CLK_PERIOD/2) clk = ~clk;

  smmu_ctrl_regs i_smmu_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_idle(dp_idle),
    .fault_valid(fault_valid), .fault_type(fault_type), .fault_addr(fault_addr),
    .xlate_en(xlate_en), .stall(stall), .inv_all(inv_all),
    .inv_entry(inv_entry), .inv_addr(inv_addr), .irq(irq)
  );

  // monitor: pops expected items and compares against the live outputs
  initial forever begin
    @(ev_push);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.what)
        W_RD:      act = reg_rdata;
        W_EN:      act = 32'(xlate_en);
        W_STALL:   act = 32'(stall);
        W_IRQ:     act = 32'(irq);
        W_INVA:    act = 32'(inv_all);
        W_INVE:    act = 32'(inv_entry);
        default:   act = inv_addr;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: item %0d actual %h expected %h", it.req, it.what, act, it.exp);
      end
    end
  end

  task automatic push(int what, logic [31:0] exp, string req);
    item_t it;
    it.what = what; it.exp = exp; it.req = req;
    q.push_back(it);
    ->ev_push;
    #1;
  endtask

  task automatic expect_rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string req);
    reg_addr = a;
    #1;
    push(W_RD, exp, req);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic fault(logic [2:0] t, logic [31:0] a);
    @(negedge clk);
    fault_valid = 1; fault_type = t; fault_addr = a;
    @(negedge clk);
    fault_valid = 0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    push(W_EN, 0, "R1"); push(W_STALL, 0, "R1"); push(W_IRQ, 0, "R1");
    push(W_INVA, 0, "R1"); push(W_INVE, 0, "R1");
    expect_rd('h000, 0, "R1"); expect_rd('h008, 0, "R1");
    expect_rd('h018, 0, "R1"); expect_rd('h014, 0, "R1");
    // R12 version
    expect_rd('h034, 32'h3000_0000, "R12");
    // R11 base and windows
    wr('h014, 32'h8000_4000);
    wr('h04C, 32'h1000_0000); wr('h050, 32'h1000_FFFF);
    wr('h054, 32'h2000_0000); wr('h058, 32'h2001_FFFF);
    expect_rd('h014, 32'h8000_4000, "R11");
    expect_rd('h04C, 32'h1000_0000, "R11"); expect_rd('h050, 32'h1000_FFFF, "R11");
    expect_rd('h054, 32'h2000_0000, "R11"); expect_rd('h058, 32'h2001_FFFF, "R11");
    // R2 enable, ignored value
    wr('h000, 5);
    push(W_EN, 1, "R2"); push(W_STALL, 0, "R2"); expect_rd('h000, 5, "R2");
    wr('h000, 3);
    expect_rd('h000, 5, "R2"); push(W_EN, 1, "R2");
    // R4 full invalidate
    wr('h00C, 1);
    push(W_INVA, 1, "R4");
    step(1);
    push(W_INVA, 0, "R4");
    wr('h00C, 0);
    push(W_INVA, 0, "R4");
    // R5 entry invalidate
    wr('h010, 32'h1234_5001);
    push(W_INVE, 1, "R5"); push(W_INVADDR, 32'h1234_5000, "R5");
    step(1);
    push(W_INVE, 0, "R5");
    wr('h010, 32'h0000_2000);
    push(W_INVE, 0, "R5");
    // R3 block handshake
    dp_idle = 0;
    wr('h000, 7);
    push(W_STALL, 1, "R3"); expect_rd('h000, 7, "R3"); expect_rd('h008, 0, "R3");
    step(2);
    expect_rd('h008, 0, "R3");
    @(negedge clk); dp_idle = 1;
    expect_rd('h008, 0, "R3");
    step(1);
    expect_rd('h008, 1, "R3");
    wr('h000, 5);
    expect_rd('h008, 0, "R3"); push(W_STALL, 0, "R3");
    dp_idle = 0;
    // R6 fault
    fault(3'd5, 32'hAAAA_0100);
    push(W_IRQ, 1, "R6"); push(W_STALL, 1, "R6");
    expect_rd('h018, 32'h20, "R6"); expect_rd('h000, 7, "R6");
    expect_rd('h02C, 32'hAAAA_0100, "R7");
    // R8 repeat type keeps address
    fault(3'd5, 32'hBBBB_0200);
    expect_rd('h02C, 32'hAAAA_0100, "R8");
    // R7 mapping
    fault(3'd1, 32'hCCCC_0300);
    expect_rd('h02C, 32'hCCCC_0300, "R7");
    fault(3'd0, 32'h0000_1400);
    expect_rd('h024, 32'h0000_1400, "R7");
    fault(3'd3, 32'h0000_3500);
    expect_rd('h030, 32'h0000_3500, "R7");
    fault(3'd6, 32'h0000_6600);
    expect_rd('h028, 32'h0000_6600, "R7");
    expect_rd('h018, 32'h6B, "R6");
    // R9 clear
    wr('h01C, 32'h20);
    expect_rd('h018, 32'h4B, "R9"); push(W_IRQ, 1, "R9");
    @(negedge clk);
    reg_we = 1; reg_addr = 'h01C; reg_wdata = 32'hFF;
    fault_valid = 1; fault_type = 3'd2; fault_addr = 32'h0000_2700;
    @(negedge clk);
    reg_we = 0; fault_valid = 0;
    expect_rd('h018, 32'h04, "R9");
    wr('h01C, 32'h04);
    expect_rd('h018, 0, "R9"); push(W_IRQ, 0, "R9");
    push(W_STALL, 1, "R9");
    // R10 disabled faults ignored
    wr('h000, 0);
    push(W_EN, 0, "R10"); push(W_STALL, 0, "R10"); expect_rd('h000, 0, "R10");
    fault(3'd0, 32'hDEAD_0000);
    step(1);
    push(W_IRQ, 0, "R10"); push(W_STALL, 0, "R10");
    expect_rd('h018, 0, "R10"); expect_rd('h024, 32'h0000_1400, "R10");
    step(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule